// File: doc/BRIEF.md
# Multi-Mode Pixel Output Formatter

This block sits at the end of a video processing pipeline and places finished pixels onto a 30-bit output bus. Each input pixel has three 12-bit channels (channel 0 is luma or green, channel 1 is Cb or blue, channel 2 is Cr or red) and comes with horizontal sync, vertical sync, field and data-enable flags. A configuration selects one of four bus formats:
- single-rate 4:4:4 on three lanes;
- single-rate 4:2:2 on two lanes;
- double-rate 4:2:2 on one lane;
- double-rate 4:4:4, which splits a 24-bit pixel into two 12-bit halves.

The configuration also selects 10-bit or 8-bit lanes, and chooses whether 4:2:2 chroma is taken from alternate pixels or averaged over each pixel pair.

Double-rate output is shown as two words per clock. `bus_rise` holds the value driven after the rising edge and `bus_fall` the value driven after the falling edge. A pad stage further on turns these two words into real edge-aligned signals. The field output can be switched to carry data-enable instead, so the bus can feed a display transmitter directly. A configuration written to the ports is held back until the next vertical sync, so a frame never mixes formats.

Top module: `pixout_formatter`

## Requirements
- R1: Each pixel appears on the outputs two clock edges after it is presented. `out_hs` and `out_vs` carry that same pixel's sync flags.
- R2: Single-rate 4:4:4 (format code 0) places channel 0 on bits 29:20, channel 1 on bits 19:10 and channel 2 on bits 9:0.
- R3: Single-rate 4:2:2 (format code 1) places luma on bits 29:20 and the chroma sample on bits 19:10. Bits 9:0 are zero.
- R4: Double-rate 4:2:2 (format code 2) places the chroma sample on bits 9:0 of the rise word and luma on bits 9:0 of the fall word. All other bits are zero.
- R5: Double-rate 4:4:4 (format code 3) forms a 24-bit pixel from the top 8 bits of channels 0, 1 and 2, with channel 0 most significant. Its upper 12 bits go on rise-word bits 11:0 and its lower 12 bits on fall-word bits 11:0. All other bits are zero.
- R6: In the single-rate formats the fall word equals the rise word, so one pixel is carried per clock.
- R7: A 10-bit lane carries channel bits 11:2. An 8-bit lane carries channel bits 11:4 in the lane's upper 8 bits, and its 2 low bits are zero.
- R8: In 4:2:2 the chroma order restarts at each first active pixel after data-enable was low. That pixel and every second one after it carry Cb; the others carry Cr.
- R9: With averaging selected, a Cb pixel carries the rounded mean (a+b+1)/2 of its own Cb and the next pixel's Cb. A Cr pixel carries the rounded mean of the previous and its own Cr. A Cb pixel whose next pixel is inactive carries its own Cb.
- R10: While data-enable is low, the lanes carry luma 0x100 and chroma 0x800 at 12-bit scale. After lane truncation this is 64/512 on a 10-bit lane and 16/128 on an 8-bit lane.
- R11: `out_fld_de` carries the pixel's field flag, or its data-enable flag when the data-enable pin option is set.
- R12: A new configuration applies from the pixel on which vertical sync rises onward. A change at any other time has no effect.
- R13: During reset all outputs are zero. Until the first vertical sync rises, the format is single-rate 4:4:4 with 8-bit lanes, no averaging and the field flag on `out_fld_de`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_de | input | 1 | Input pixel is active video |
| pix_hs | input | 1 | Horizontal sync flag |
| pix_vs | input | 1 | Vertical sync flag |
| pix_field | input | 1 | Field flag |
| pix_c0 | input | 12 | Channel 0 (luma / green) |
| pix_c1 | input | 12 | Channel 1 (Cb / blue) |
| pix_c2 | input | 12 | Channel 2 (Cr / red) |
| cfg_fmt | input | 2 | Bus format code 0..3 |
| cfg_wide | input | 1 | 1 = 10-bit lanes, 0 = 8-bit lanes |
| cfg_avg | input | 1 | Average chroma pairs in 4:2:2 |
| cfg_de_pin | input | 1 | Drive data-enable on `out_fld_de` |
| bus_rise | output | 30 | Word driven after the rising edge |
| bus_fall | output | 30 | Word driven after the falling edge |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_fld_de | output | 1 | Field or data-enable output |

## Verification
The hardest case to reach is a configuration change that arrives in the middle of a frame while chroma pairing is in progress. Such a change must stay invisible until the next vertical sync rises, and the Cb/Cr order must restart correctly after gaps of one pixel and after runs of odd length. The bench sweeps all 32 configurations. In every sweep it changes the configuration ports partway through the frame. In alternate sweeps it then raises a second vertical sync, so both the ignored case and the applied case are checked. The data-enable pattern contains even runs, odd runs, a single-pixel run and a one-pixel gap, and full-scale channel values test rounding at the top of the range.

// File: rtl/pixout_pkg.sv
package pixout_pkg;

   typedef enum logic [1:0] {
      FMT_SDR444 = 2'd0,
      FMT_SDR422 = 2'd1,
      FMT_DDR422 = 2'd2,
      FMT_DDR444 = 2'd3
   } fmt_e;

   typedef struct packed {
      fmt_e fmt;
      logic wide;
      logic avg;
      logic de_pin;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{fmt: FMT_SDR444, wide: 1'b0, avg: 1'b0, de_pin: 1'b0};

endpackage

// File: rtl/pixout_stage.sv
module pixout_stage
   import pixout_pkg::*;
#(
   parameter int CH_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pix_de,
   input  logic            pix_hs,
   input  logic            pix_vs,
   input  logic            pix_field,
   input  logic [CH_W-1:0] pix_c0,
   input  logic [CH_W-1:0] pix_c1,
   input  logic [CH_W-1:0] pix_c2,
   input  cfg_t            cfg_in,
   output logic            a_de,
   output logic            a_hs,
   output logic            a_vs,
   output logic            a_fld,
   output logic [CH_W-1:0] a_c0,
   output logic [CH_W-1:0] a_c1,
   output logic [CH_W-1:0] a_c2,
   output logic [CH_W-1:0] b_c2,
   output logic            phase,
   output cfg_t            cfg_act
);

   logic b_de;
   logic vs_rise;

   // the pixel being captured starts a vertical sync
   assign vs_rise = pix_vs & ~a_vs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_de    <= 1'b0;
         a_hs    <= 1'b0;
         a_vs    <= 1'b0;
         a_fld   <= 1'b0;
         a_c0    <= '0;
         a_c1    <= '0;
         a_c2    <= '0;
         b_de    <= 1'b0;
         b_c2    <= '0;
         phase   <= 1'b0;
         cfg_act <= CFG_RESET;
      end else begin
         a_de    <= pix_de;
         a_hs    <= pix_hs;
         a_vs    <= pix_vs;
         a_fld   <= pix_field;
         a_c0    <= pix_c0;
         a_c1    <= pix_c1;
         a_c2    <= pix_c2;
         b_de    <= a_de;
         b_c2    <= a_c2;
         // chroma order restarts after any inactive pixel
         phase   <= a_de ? ~phase : 1'b0;
         if (vs_rise)
            cfg_act <= cfg_in;
      end
   end

   // R8: a Cr slot always follows an active Cb pixel
   a_r8_cr_has_partner: assert property (@(posedge clk) disable iff (!rst_n)
      phase |-> b_de);

   // R12: configuration only moves on a vertical sync rising edge
   a_r12_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_vs && !a_vs) |=> $stable(cfg_act));

endmodule

// File: rtl/pixout_chroma.sv
module pixout_chroma #(
   parameter int CH_W = 12
) (
   input  logic            avg_en,
   input  logic            phase,
   input  logic [CH_W-1:0] cur_cb,
   input  logic [CH_W-1:0] cur_cr,
   input  logic [CH_W-1:0] prv_cr,
   input  logic            nxt_de,
   input  logic [CH_W-1:0] nxt_cb,
   output logic [CH_W-1:0] chroma
);

   localparam int SUM_W = CH_W + 1;

   function automatic logic [CH_W-1:0] mean2(input logic [CH_W-1:0] x, input logic [CH_W-1:0] y);
      logic [SUM_W-1:0] s;
      s = {1'b0, x} + {1'b0, y} + SUM_W'(1);
      return s[SUM_W-1:1];
   endfunction

   logic [CH_W-1:0] cb_pair;
   logic [CH_W-1:0] cr_pair;

   assign cb_pair = nxt_de ? mean2(cur_cb, nxt_cb) : cur_cb;
   assign cr_pair = mean2(prv_cr, cur_cr);

   always_comb begin
      if (avg_en)
         chroma = phase ? cr_pair : cb_pair;
      else
         chroma = phase ? cur_cr : cur_cb;
   end

endmodule

// File: rtl/pixout_pack.sv
module pixout_pack
   import pixout_pkg::*;
#(
   parameter int              CH_W     = 12,
   parameter int              LANE_W   = 10,
   parameter int              NARROW_W = 8,
   parameter int              DDR_W    = 12,
   parameter logic [CH_W-1:0] BLACK    = 12'h100,
   parameter logic [CH_W-1:0] MID      = 12'h800,
   localparam int             BUS_W    = 3 * LANE_W
) (
   input  fmt_e             fmt,
   input  logic             wide,
   input  logic             de,
   input  logic [CH_W-1:0]  c0,
   input  logic [CH_W-1:0]  c1,
   input  logic [CH_W-1:0]  c2,
   input  logic [CH_W-1:0]  chroma,
   output logic [BUS_W-1:0] rise,
   output logic [BUS_W-1:0] fall
);

   localparam int NSRC  = 4;
   localparam int PAD_W = LANE_W - NARROW_W;
   localparam int PIX_W = 3 * NARROW_W;

   initial begin
      a_cfg_lane: assert (CH_W >= LANE_W && LANE_W > NARROW_W)
         else $error("lane widths inconsistent with channel width");
      a_cfg_ddr: assert (2 * DDR_W == PIX_W && DDR_W <= BUS_W)
         else $error("double-rate half width must split the narrow pixel");
   end

   logic [CH_W-1:0]     src  [NSRC];
   logic [LANE_W-1:0]   lane [NSRC];
   logic [NARROW_W-1:0] nar  [NSRC];
   logic [PIX_W-1:0]    pix24;

   // blanking substitution: index 0 is luma, the rest are chroma-like
   assign src[0] = de ? c0     : BLACK;
   assign src[1] = de ? c1     : MID;
   assign src[2] = de ? c2     : MID;
   assign src[3] = de ? chroma : MID;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_lane
      assign nar[gi]  = src[gi][CH_W-1 -: NARROW_W];
      assign lane[gi] = wide ? src[gi][CH_W-1 -: LANE_W] : {nar[gi], {PAD_W{1'b0}}};
   end

   assign pix24 = {nar[0], nar[1], nar[2]};

   always_comb begin
      rise = '0;
      fall = '0;
      unique case (fmt)
         FMT_SDR444: begin
            rise = {lane[0], lane[1], lane[2]};
            fall = rise;
         end
         FMT_SDR422: begin
            rise = {lane[0], lane[3], {LANE_W{1'b0}}};
            fall = rise;
         end
         FMT_DDR422: begin
            rise[LANE_W-1:0] = lane[3];
            fall[LANE_W-1:0] = lane[0];
         end
         FMT_DDR444: begin
            rise[DDR_W-1:0] = pix24[PIX_W-1 -: DDR_W];
            fall[DDR_W-1:0] = pix24[DDR_W-1:0];
         end
         default: begin
            rise = '0;
            fall = '0;
         end
      endcase
   end

endmodule

// File: rtl/pixout_formatter.sv
module pixout_formatter
   import pixout_pkg::*;
#(
   parameter int              CH_W     = 12,
   parameter int              LANE_W   = 10,
   parameter int              NARROW_W = 8,
   parameter int              DDR_W    = 12,
   parameter logic [CH_W-1:0] BLACK    = 12'h100,
   parameter logic [CH_W-1:0] MID      = 12'h800,
   localparam int             BUS_W    = 3 * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_de,
   input  logic             pix_hs,
   input  logic             pix_vs,
   input  logic             pix_field,
   input  logic [CH_W-1:0]  pix_c0,
   input  logic [CH_W-1:0]  pix_c1,
   input  logic [CH_W-1:0]  pix_c2,
   input  logic [1:0]       cfg_fmt,
   input  logic             cfg_wide,
   input  logic             cfg_avg,
   input  logic             cfg_de_pin,
   output logic [BUS_W-1:0] bus_rise,
   output logic [BUS_W-1:0] bus_fall,
   output logic             out_hs,
   output logic             out_vs,
   output logic             out_fld_de
);

   cfg_t            cfg_in;
   cfg_t            cfg_act;
   logic            a_de, a_hs, a_vs, a_fld, phase;
   logic [CH_W-1:0] a_c0, a_c1, a_c2, b_c2;
   logic [CH_W-1:0] chroma;
   logic [BUS_W-1:0] rise_d, fall_d;
   fmt_e            fmt_q;

   assign cfg_in = '{fmt: fmt_e'(cfg_fmt), wide: cfg_wide, avg: cfg_avg, de_pin: cfg_de_pin};

   pixout_stage #(.CH_W(CH_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_field(pix_field),
      .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2),
      .cfg_in(cfg_in),
      .a_de(a_de), .a_hs(a_hs), .a_vs(a_vs), .a_fld(a_fld),
      .a_c0(a_c0), .a_c1(a_c1), .a_c2(a_c2), .b_c2(b_c2),
      .phase(phase), .cfg_act(cfg_act)
   );

   // the input port holds the pixel after the staged one
   pixout_chroma #(.CH_W(CH_W)) u_chroma (
      .avg_en(cfg_act.avg), .phase(phase),
      .cur_cb(a_c1), .cur_cr(a_c2), .prv_cr(b_c2),
      .nxt_de(pix_de), .nxt_cb(pix_c1),
      .chroma(chroma)
   );

   pixout_pack #(
      .CH_W(CH_W), .LANE_W(LANE_W), .NARROW_W(NARROW_W),
      .DDR_W(DDR_W), .BLACK(BLACK), .MID(MID)
   ) u_pack (
      .fmt(cfg_act.fmt), .wide(cfg_act.wide), .de(a_de),
      .c0(a_c0), .c1(a_c1), .c2(a_c2), .chroma(chroma),
      .rise(rise_d), .fall(fall_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rise   <= '0;
         bus_fall   <= '0;
         out_hs     <= 1'b0;
         out_vs     <= 1'b0;
         out_fld_de <= 1'b0;
         fmt_q      <= FMT_SDR444;
      end else begin
         bus_rise   <= rise_d;
         bus_fall   <= fall_d;
         out_hs     <= a_hs;
         out_vs     <= a_vs;
         out_fld_de <= cfg_act.de_pin ? a_de : a_fld;
         fmt_q      <= cfg_act.fmt;
      end
   end

   // R6: single-rate formats carry one word per clock
   a_r6_single_word: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q == FMT_SDR444 || fmt_q == FMT_SDR422) |-> (bus_fall == bus_rise));

   // R4, R5: double-rate formats leave the upper pins quiet
   a_r5_ddr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q == FMT_DDR444 || fmt_q == FMT_DDR422) |->
         (bus_rise[BUS_W-1:DDR_W] == '0 && bus_fall[BUS_W-1:DDR_W] == '0));

   // R1: sync outputs trail the staged pixel by one register
   a_r1_vs_align: assert property (@(posedge clk) disable iff (!rst_n)
      out_vs == $past(a_vs));

   a_r1_hs_align: assert property (@(posedge clk) disable iff (!rst_n)
      out_hs == $past(a_hs));

endmodule

// File: tb/pixout_formatter_bench.sv
`timescale 1ns/1ps
module pixout_formatter_bench;

   localparam int N = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_de = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0, pix_field = 1'b0;
   logic [11:0] pix_c0 = '0, pix_c1 = '0, pix_c2 = '0;
   logic [1:0]  cfg_fmt = '0;
   logic        cfg_wide = 1'b0, cfg_avg = 1'b0, cfg_de_pin = 1'b0;
   logic [29:0] bus_rise, bus_fall;
   logic        out_hs, out_vs, out_fld_de;

   pixout_formatter u_pixout_formatter (
      .clk(clk), .rst_n(rst_n),
      .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_field(pix_field),
      .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2),
      .cfg_fmt(cfg_fmt), .cfg_wide(cfg_wide), .cfg_avg(cfg_avg), .cfg_de_pin(cfg_de_pin),
      .bus_rise(bus_rise), .bus_fall(bus_fall),
      .out_hs(out_hs), .out_vs(out_vs), .out_fld_de(out_fld_de)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // stimulus of the current sweep; cfg packs {fmt[4:3], wide[2], avg[1], de_pin[0]}
   logic        st_de [N], st_hs [N], st_vs [N], st_fld [N], ph [N];
   logic [11:0] s0 [N], s1 [N], s2 [N];
   logic [4:0]  st_cfg [N], act [N];
   logic [4:0]  act_prev = 5'd0;
   logic        vs_prev  = 1'b0;
   int          cur_pass;
   bit          cur_pre;

   task automatic chk(string tag, int k, logic [29:0] got, logic [29:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s pass %0d pixel %0d: got %h expected %h", tag, cur_pass, k, got, exp);
      end
   endtask

   function automatic logic [9:0] lane(logic [11:0] x, logic wide);
      return wide ? x[11:2] : {x[11:4], 2'b00};
   endfunction

   function automatic logic [11:0] mean2(logic [11:0] a, logic [11:0] b);
      int s;
      s = (int'(a) + int'(b) + 1) / 2;
      return s[11:0];
   endfunction

   task automatic build(int pass, bit pre);
      logic [4:0] base, alt;
      base = pass[4:0];
      alt  = {base[4:3] + 2'd1, ~base[2], base[1], ~base[0]};
      for (int k = 0; k < N; k++) begin
         st_vs[k]  = pre ? 1'b0 : (k == 0 || (pass[0] && k == 30));
         st_hs[k]  = (k % 16 == 1) || (k % 16 == 2);
         st_fld[k] = k[4];
         st_de[k]  = (k >= 4 && k <= 13) || (k >= 15 && k <= 21) || k == 24 || (k >= 27 && k <= 44);
         s0[k]     = 12'((k * 283 + pass * 97) & 12'hFFF);
         s1[k]     = (k % 11 == 0) ? 12'hFFF : 12'((k * 517 + pass * 31 + 5) & 12'hFFF);
         s2[k]     = (k % 7 == 0)  ? 12'hFFF : 12'((k * 1231 + pass * 13 + 1) & 12'hFFF);
         st_cfg[k] = pre ? 5'b11101 : ((k < 20) ? base : alt);
      end
      for (int k = 0; k < N; k++) begin
         if (st_vs[k] && !vs_prev) act_prev = st_cfg[k];
         vs_prev = st_vs[k];
         act[k]  = act_prev;
         ph[k]   = (k == 0) ? 1'b0 : (st_de[k-1] ? ~ph[k-1] : 1'b0);
      end
   endtask

   task automatic check_pix(int k);
      logic [4:0]  m;
      logic [11:0] y, a1, a2, cr;
      logic [23:0] p24;
      logic [29:0] er, ef;
      string       tr, tf;
      m  = act[k];
      y  = st_de[k] ? s0[k] : 12'h100;
      a1 = st_de[k] ? s1[k] : 12'h800;
      a2 = st_de[k] ? s2[k] : 12'h800;
      if (!m[1])
         cr = ph[k] ? s2[k] : s1[k];
      else if (!ph[k])
         cr = (k + 1 < N && st_de[k+1]) ? mean2(s1[k], s1[k+1]) : s1[k];
      else
         cr = mean2(s2[k-1], s2[k]);
      if (!st_de[k]) cr = 12'h800;
      p24 = {y[11:4], a1[11:4], a2[11:4]};
      case (m[4:3])
         2'd0:    begin er = {lane(y, m[2]), lane(a1, m[2]), lane(a2, m[2])}; ef = er; end
         2'd1:    begin er = {lane(y, m[2]), lane(cr, m[2]), 10'd0}; ef = er; end
         2'd2:    begin er = {20'd0, lane(cr, m[2])}; ef = {20'd0, lane(y, m[2])}; end
         default: begin er = {18'd0, p24[23:12]}; ef = {18'd0, p24[11:0]}; end
      endcase
      // choose the requirement each rise-word comparison chiefly exercises
      if (cur_pre)                                        tr = "R13";
      else if (k >= 20 && (k < 30 || !cur_pass[0]))       tr = "R12";
      else if (!st_de[k])                                 tr = "R10";
      else if ((m[4:3] == 2'd1 || m[4:3] == 2'd2) && m[1]) tr = "R9";
      else if ((m[4:3] == 2'd1 || m[4:3] == 2'd2) && ph[k]) tr = "R8";
      else if (!m[2] && m[4:3] != 2'd3)                   tr = "R7";
      else if (m[4:3] == 2'd0)                            tr = "R2";
      else if (m[4:3] == 2'd1)                            tr = "R3";
      else if (m[4:3] == 2'd2)                            tr = "R4";
      else                                                tr = "R5";
      tf = (m[4:3] < 2'd2) ? "R6" : (m[4:3] == 2'd2 ? "R4" : "R5");
      chk(tr, k, bus_rise, er);
      chk(tf, k, bus_fall, ef);
      chk("R1", k, {29'd0, out_hs}, {29'd0, st_hs[k]});
      chk("R1", k, {29'd0, out_vs}, {29'd0, st_vs[k]});
      chk("R11", k, {29'd0, out_fld_de}, {29'd0, (m[0] ? st_de[k] : st_fld[k])});
   endtask

   task automatic run_pass(int pass, bit pre);
      cur_pass = pass;
      cur_pre  = pre;
      build(pass, pre);
      for (int j = 0; j < N + 2; j++) begin
         @(negedge clk);
         if (j >= 2) check_pix(j - 2);
         if (j < N) begin
            pix_de = st_de[j]; pix_hs = st_hs[j]; pix_vs = st_vs[j]; pix_field = st_fld[j];
            pix_c0 = s0[j]; pix_c1 = s1[j]; pix_c2 = s2[j];
            {cfg_fmt, cfg_wide, cfg_avg, cfg_de_pin} = st_cfg[j];
         end else begin
            pix_de = 1'b0; pix_hs = 1'b0; pix_vs = 1'b0; pix_field = 1'b0;
            pix_c0 = '0; pix_c1 = '0; pix_c2 = '0;
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset clears every output
      chk("R13", -1, bus_rise, 30'd0);
      chk("R13", -1, bus_fall, 30'd0);
      chk("R13", -1, {27'd0, out_hs, out_vs, out_fld_de}, 30'd0);
      rst_n = 1'b1;
      // R13: no vertical sync yet, so the reset format must be in force
      run_pass(99, 1'b1);
      for (int p = 0; p < 32; p++) run_pass(p, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule